// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Sequencer

This block is a synchronous controller for a 32-bit-wide DRAM with extended-data-out behaviour. It turns a stream of column requests from a host into the row-strobe, column-strobe, write-enable and multiplexed address waveforms the memory expects. A request to a row that is not open starts a row activation. After that, every further request to the same row costs only one column-strobe cycle, and the row stays open.

Read data is sampled at the end of the column-strobe high phase. The data-out hold of the memory keeps it valid there, so the strobe low pulse stays at its minimum and the access time is covered while the strobe is high. The row is closed when the host stops requesting, when a request targets another row, or when the row-strobe low time would run past its legal maximum. Every timing rule is given in nanoseconds as a parameter and rounded up to whole clock cycles.

The host side uses a simple grant handshake. The host holds `req` with its fields stable until it samples `ready` high. Reads return on `rdata` with a one-cycle `rvalid` pulse, in request order.

Top module: `edoPageSeq`

## Requirements
- R1: While reset is held, `rasN`, `casN` and `weN` are high and `dqOe`, `ready` and `rvalid` are low.
- R2: A request with no row open causes `rasN` to fall with the row on `addr`. `casN` first falls at least 2 cycles later. Further requests to the same row are served without another `rasN` fall.
- R3: A request to a row other than the open one makes `rasN` go high and then fall again for the new row. Each `rasN` high interval lasts at least 4 cycles (40 ns).
- R4: Each `casN` low pulse lasts exactly 1 cycle, which meets the 10 ns minimum and stays under the 10 us maximum. `casN` is low only while `rasN` is low.
- R5: For a read, `rvalid` pulses for one cycle, 5 cycles after the cycle in which `casN` falls. `rdata` then holds the word the memory drove on `dqIn` for that column. Reads return in request order.
- R6: For a write, `dqOut` carries the request's `wdata` while `casN` is low. `dqOe` is high only when `weN`, `casN` and `rasN` are all low.
- R7: A write that follows a read within the same open row drives `weN` low for at least 1 cycle before `dqOe` rises.
- R8: `rasN` stays low for at most T_RASP_NS/CLK_NS cycles. Once the remaining time cannot cover another full column cycle plus the closing hold, the sequencer stops granting and closes the row. Held requests then reopen it.
- R9: After the last `casN` rise of a row, `rasN` stays low for at least 4 cycles (35 ns rounded up).
- R10: When `req` goes low with a row open, the row is closed, and within 12 cycles `rasN` is high.
- R11: `ready` is high only while `req` is high. Each high cycle of `ready` accepts exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request pending |
| we | input | 1 | Request is a write (1) or a read (0) |
| row | input | ROW_W | Row address of the request |
| col | input | COL_W | Column address of the request |
| wdata | input | DATA_W | Write data of the request |
| ready | output | 1 | Grant: the request on the inputs is taken this cycle |
| rdata | output | DATA_W | Read data |
| rvalid | output | 1 | One-cycle pulse marking valid `rdata` |
| rasN | output | 1 | Row strobe to the memory, active low |
| casN | output | 1 | Column strobe to the memory, active low |
| weN | output | 1 | Write enable to the memory, active low |
| addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dqOut | output | DATA_W | Data driven to the memory |
| dqOe | output | 1 | Enable for `dqOut` onto the data bus |
| dqIn | input | DATA_W | Data returned by the memory |

## Verification
On every cycle the assertions check the strobe rules: the column strobe only inside an open row, the column-strobe pulse width, the minimum row precharge, the hold after the last column precharge, the maximum row-low time, and bus drive only under write enable. They also check the grant and valid pulse shapes. Only the bench scenarios can show that the right words come back from a memory model in request order. The same holds for the number of row activations matching the row changes, the write-after-read turnaround, and a long same-row stream that is split into several pages.

// File: rtl/edoSeqPkg.sv
package edoSeqPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACT,
    S_OPEN,
    S_TURN,
    S_CASLO,
    S_CASHI,
    S_HOLD,
    S_PRE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchRow;
    logic latchCol;
    logic selRow;
    logic driveDq;
    logic capture;
  } dpCtrl_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edoSeqCtrl.sv
module edoSeqCtrl
  import edoSeqPkg::*;
#(
  parameter int CL   = 1,
  parameter int CHR  = 4,
  parameter int CHW  = 2,
  parameter int WHZ  = 1,
  parameter int RCD  = 2,
  parameter int RP   = 4,
  parameter int RH   = 4,
  parameter int RASP = 12500
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    we,
  input  logic    rowHit,
  output logic    ready,
  output logic    rasN,
  output logic    casN,
  output logic    weN,
  output dpCtrl_t dp
);

  localparam int MAXC      = maxInt(maxInt(maxInt(CL, CHR), maxInt(CHW, WHZ)),
                                    maxInt(maxInt(RCD, RP), RH));
  localparam int CNT_W     = $clog2(MAXC + 1);
  localparam int GUARD     = 2 + WHZ + CL + CHR + RH;
  localparam int RAS_LIMIT = RASP - GUARD;
  localparam int RASCNT_W  = $clog2(RASP + 1);
  localparam bit HAS_TURN  = (WHZ > 0);

  seqState_t             state, nextState;
  logic [CNT_W-1:0]      cnt, nextCnt;
  logic [RASCNT_W-1:0]   rasCnt;
  logic                  opWe;
  logic                  lastRead;
  logic                  expire;
  logic                  accept;

  assign expire = (rasCnt > RASCNT_W'(RAS_LIMIT));

  always_comb begin
    nextState = state;
    nextCnt   = (cnt == '0) ? '0 : cnt - 1'b1;
    dp        = '0;
    rasN      = 1'b1;
    casN      = 1'b1;
    weN       = 1'b1;
    ready     = 1'b0;
    accept    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (req) begin
          dp.latchRow = 1'b1;
          nextState   = S_ACT;
          nextCnt     = CNT_W'(RCD - 1);
        end
      end
      S_ACT: begin
        rasN      = 1'b0;
        dp.selRow = 1'b1;
        if (cnt == '0) nextState = S_OPEN;
      end
      S_OPEN: begin
        rasN = 1'b0;
        if (req && rowHit && !expire) begin
          ready       = 1'b1;
          accept      = 1'b1;
          dp.latchCol = 1'b1;
          if (HAS_TURN && we && lastRead) begin
            nextState = S_TURN;
            nextCnt   = CNT_W'(maxInt(WHZ, 1) - 1);
          end else begin
            nextState = S_CASLO;
            nextCnt   = CNT_W'(CL - 1);
          end
        end else begin
          nextState = S_HOLD;
          nextCnt   = CNT_W'(RH - 1);
        end
      end
      S_TURN: begin
        rasN = 1'b0;
        weN  = 1'b0;
        if (cnt == '0) begin
          nextState = S_CASLO;
          nextCnt   = CNT_W'(CL - 1);
        end
      end
      S_CASLO: begin
        rasN       = 1'b0;
        casN       = 1'b0;
        weN        = !opWe;
        dp.driveDq = opWe;
        if (cnt == '0) begin
          nextState = S_CASHI;
          nextCnt   = opWe ? CNT_W'(CHW - 1) : CNT_W'(CHR - 1);
        end
      end
      S_CASHI: begin
        rasN = 1'b0;
        if (cnt == '0) begin
          nextState  = S_OPEN;
          dp.capture = !opWe;
        end
      end
      S_HOLD: begin
        rasN = 1'b0;
        if (cnt == '0) begin
          nextState = S_PRE;
          nextCnt   = CNT_W'(RP - 1);
        end
      end
      S_PRE: begin
        if (cnt == '0) nextState = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      rasCnt   <= '0;
      opWe     <= 1'b0;
      lastRead <= 1'b0;
    end else begin
      state  <= nextState;
      cnt    <= nextCnt;
      rasCnt <= rasN ? '0 : rasCnt + 1'b1;
      if (accept) opWe <= we;
      if (state == S_ACT) lastRead <= 1'b0;
      else if (state == S_CASHI && cnt == '0) lastRead <= !opWe;
    end
  end

endmodule

// File: rtl/edoSeqData.sv
module edoSeqData
  import edoSeqPkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dp,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dqIn,
  output logic              rowHit,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [ROW_W-1:0]  openRow;
  logic [COL_W-1:0]  colReg;
  logic [DATA_W-1:0] wdataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openRow  <= '0;
      colReg   <= '0;
      wdataReg <= '0;
      rdata    <= '0;
      rvalid   <= 1'b0;
    end else begin
      if (dp.latchRow) openRow <= row;
      if (dp.latchCol) begin
        colReg   <= col;
        wdataReg <= wdata;
      end
      if (dp.capture) rdata <= dqIn;
      rvalid <= dp.capture;
    end
  end

  assign rowHit = (row == openRow);
  assign addr   = dp.selRow ? ADDR_W'(openRow) : ADDR_W'(colReg);
  assign dqOut  = wdataReg;
  assign dqOe   = dp.driveDq;

endmodule

// File: rtl/edoPageSeq.sv
module edoPageSeq
  import edoSeqPkg::*;
#(
  parameter int ROW_W      = 11,
  parameter int COL_W      = 10,
  parameter int DATA_W     = 32,
  parameter int CLK_NS     = 10,
  parameter int T_CAS_NS   = 10,
  parameter int T_PAGE_NS  = 25,
  parameter int T_CPA_NS   = 35,
  parameter int T_RHOLD_NS = 35,
  parameter int T_WHZ_NS   = 10,
  parameter int T_RCD_NS   = 20,
  parameter int T_RP_NS    = 40,
  parameter int T_RASP_NS  = 125000,
  localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  input  logic [DATA_W-1:0] dqIn
);

  localparam int CL_CYC   = maxInt(ceilDiv(T_CAS_NS, CLK_NS), 1);
  localparam int HPC_CYC  = ceilDiv(T_PAGE_NS, CLK_NS);
  localparam int CPA_CYC  = ceilDiv(T_CPA_NS, CLK_NS);
  localparam int CHR_CYC  = maxInt(maxInt(HPC_CYC - CL_CYC, CPA_CYC), 1);
  localparam int CHW_CYC  = maxInt(HPC_CYC - CL_CYC, 1);
  localparam int WHZ_CYC  = ceilDiv(T_WHZ_NS, CLK_NS);
  localparam int RCD_CYC  = maxInt(ceilDiv(T_RCD_NS, CLK_NS), 1);
  localparam int RP_CYC   = maxInt(ceilDiv(T_RP_NS, CLK_NS), 1);
  localparam int RH_CYC   = maxInt(ceilDiv(T_RHOLD_NS, CLK_NS), 1);
  localparam int RASP_CYC = T_RASP_NS / CLK_NS;

  dpCtrl_t dpStrobe;
  logic    rowHit;

  edoSeqCtrl #(
    .CL  (CL_CYC),
    .CHR (CHR_CYC),
    .CHW (CHW_CYC),
    .WHZ (WHZ_CYC),
    .RCD (RCD_CYC),
    .RP  (RP_CYC),
    .RH  (RH_CYC),
    .RASP(RASP_CYC)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .req   (req),
    .we    (we),
    .rowHit(rowHit),
    .ready (ready),
    .rasN  (rasN),
    .casN  (casN),
    .weN   (weN),
    .dp    (dpStrobe)
  );

  edoSeqData #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_data (
    .clk   (clk),
    .rstN  (rstN),
    .dp    (dpStrobe),
    .row   (row),
    .col   (col),
    .wdata (wdata),
    .dqIn  (dqIn),
    .rowHit(rowHit),
    .addr  (addr),
    .dqOut (dqOut),
    .dqOe  (dqOe),
    .rdata (rdata),
    .rvalid(rvalid)
  );

endmodule

// File: rtl/edoPageSeqChk.sv
module edoPageSeqChk #(
  parameter int CLK_NS       = 10,
  parameter int T_CAS_NS     = 10,
  parameter int T_CASMAX_NS  = 10000,
  parameter int T_RHOLD_NS   = 35,
  parameter int T_RP_NS      = 40,
  parameter int T_RASP_NS    = 125000
) (
  input logic clk,
  input logic rstN,
  input logic req,
  input logic ready,
  input logic rvalid,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic dqOe
);

  localparam int CL_MIN  = (T_CAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int CL_MAX  = T_CASMAX_NS / CLK_NS;
  localparam int RH_MIN  = (T_RHOLD_NS + CLK_NS - 1) / CLK_NS;
  localparam int RP_MIN  = (T_RP_NS + CLK_NS - 1) / CLK_NS;
  localparam int RAS_MAX = T_RASP_NS / CLK_NS;
  localparam int SAT     = RAS_MAX + CL_MAX + RP_MIN + RH_MIN + 8;

  int casLowRun, casHighRun, rasLowRun, rasHighRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      casLowRun  <= 0;
      casHighRun <= SAT;
      rasLowRun  <= 0;
      rasHighRun <= SAT;
    end else begin
      casLowRun  <= casN ? 0 : ((casLowRun < SAT) ? casLowRun + 1 : SAT);
      casHighRun <= !casN ? 0 : ((casHighRun < SAT) ? casHighRun + 1 : SAT);
      rasLowRun  <= rasN ? 0 : ((rasLowRun < SAT) ? rasLowRun + 1 : SAT);
      rasHighRun <= !rasN ? 0 : ((rasHighRun < SAT) ? rasHighRun + 1 : SAT);
    end
  end

  // R4: column strobe only inside an open row
  a_r4_cas_in_row: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);

  // R4: column strobe pulse width within limits
  a_r4_cas_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casN) |-> (casLowRun >= CL_MIN && casLowRun <= CL_MAX));

  // R3: minimum row precharge
  a_r3_precharge_min: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> rasHighRun >= RP_MIN);

  // R9: row strobe held after last column precharge
  a_r9_ras_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> casHighRun >= RH_MIN);

  // R8: row strobe low time bounded
  a_r8_ras_max: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> rasLowRun < RAS_MAX);

  // R6: bus driven only inside a write column cycle
  a_r6_drive_gated: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (!weN && !casN && !rasN));

  // R5: read valid is a single-cycle pulse
  a_r5_rvalid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rvalid |=> !rvalid);

  // R11: grant only with a pending request, one cycle each
  a_r11_ready_req: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> req);

  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);

endmodule

bind edoPageSeq edoPageSeqChk #(
  .CLK_NS    (CLK_NS),
  .T_CAS_NS  (T_CAS_NS),
  .T_RHOLD_NS(T_RHOLD_NS),
  .T_RP_NS   (T_RP_NS),
  .T_RASP_NS (T_RASP_NS)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .req   (req),
  .ready (ready),
  .rvalid(rvalid),
  .rasN  (rasN),
  .casN  (casN),
  .weN   (weN),
  .dqOe  (dqOe)
);

// File: tb/edoPageSeq_tb.sv
module edoPageSeq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 11;
  localparam int COL_W  = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 11;
  localparam int RASP_NS  = 1000;
  localparam int RASP_CYC = 100;
  localparam int NVEC = 13;

  // {we, row[3:0], col[3:0], wdata}
  localparam logic [40:0] VEC [0:NVEC-1] = '{
    {1'b1, 4'd1, 4'd2,  32'hDEADBEEF},
    {1'b0, 4'd1, 4'd2,  32'h0},
    {1'b0, 4'd1, 4'd3,  32'h0},
    {1'b1, 4'd1, 4'd3,  32'h12345678},
    {1'b0, 4'd1, 4'd3,  32'h0},
    {1'b0, 4'd2, 4'd0,  32'h0},
    {1'b1, 4'd2, 4'd1,  32'hCAFEF00D},
    {1'b1, 4'd2, 4'd2,  32'h0BADC0DE},
    {1'b0, 4'd2, 4'd1,  32'h0},
    {1'b0, 4'd1, 4'd2,  32'h0},
    {1'b0, 4'd2, 4'd2,  32'h0},
    {1'b1, 4'd3, 4'd15, 32'hFFFFFFFF},
    {1'b0, 4'd3, 4'd15, 32'h0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic req = 1'b0;
  logic weIn = 1'b0;
  logic [ROW_W-1:0]  rowIn = '0;
  logic [COL_W-1:0]  colIn = '0;
  logic [DATA_W-1:0] wdataIn = '0;
  logic [DATA_W-1:0] dqIn = '0;
  logic              ready, rvalid, rasN, casN, weN, dqOe;
  logic [DATA_W-1:0] rdata, dqOut;
  logic [ADDR_W-1:0] addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  edoPageSeq #(.T_RASP_NS(RASP_NS)) u_dut (
    .clk(clk), .rstN(rstN), .req(req), .we(weIn), .row(rowIn), .col(colIn),
    .wdata(wdataIn), .ready(ready), .rdata(rdata), .rvalid(rvalid),
    .rasN(rasN), .casN(casN), .weN(weN), .addr(addr), .dqOut(dqOut),
    .dqOe(dqOe), .dqIn(dqIn)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] modelMem [0:255];
  logic [31:0] expMem   [0:255];
  logic [31:0] expFifo  [0:511];
  int fifoHead = 0, fifoTail = 0;
  int activations = 0;
  bit monOn = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model and timing monitor, sampled on the falling edge
  logic [3:0] modelRow = '0;
  logic prevRasN = 1'b1, prevCasN = 1'b1, prevWeN = 1'b1, prevDqOe = 1'b0;
  int rasHighCnt = 1000, rasLowCnt = 0, casLowCnt = 0;
  int sinceCasRise = 1000, sinceRasFall = 0, readLat = 0;
  bit readPending = 1'b0, lastRead = 1'b0;

  always @(negedge clk) begin
    if (rstN && monOn) begin
      if (ready) chk(req, "R11", "ready without req", {31'b0, req}, 32'd1);
      if (dqOe && !prevDqOe && lastRead)
        chk(!prevWeN, "R7", "weN low before drive", {31'b0, prevWeN}, 32'd0);
      if (!rasN && prevRasN) begin
        chk(rasHighCnt >= 4, "R3", "precharge cycles", rasHighCnt, 32'd4);
        activations++;
        modelRow = addr[3:0];
        lastRead = 1'b0;
      end
      if (rasN && !prevRasN) begin
        chk(sinceCasRise + 1 >= 4, "R9", "hold after cas rise", sinceCasRise + 1, 32'd4);
        chk(rasLowCnt <= RASP_CYC, "R8", "ras low cycles", rasLowCnt, RASP_CYC);
      end
      if (!casN && prevCasN) begin
        chk(!rasN, "R4", "cas low with ras high", {31'b0, rasN}, 32'd0);
        chk(sinceRasFall + 1 >= 2, "R2", "ras-to-cas cycles", sinceRasFall + 1, 32'd2);
        if (weN) begin
          dqIn = modelMem[{modelRow, addr[3:0]}];
          readPending = 1'b1;
          lastRead = 1'b1;
        end else begin
          chk(dqOe, "R6", "dqOe during write cas", {31'b0, dqOe}, 32'd1);
          modelMem[{modelRow, addr[3:0]}] = dqOut;
          lastRead = 1'b0;
        end
      end
      if (casN && !prevCasN)
        chk(casLowCnt == 1, "R4", "cas low width", casLowCnt, 32'd1);
      if (rvalid) begin
        chk(readPending && (readLat + 1 == 5), "R5", "rvalid latency", readLat + 1, 32'd5);
        if (fifoHead < fifoTail) begin
          chk(rdata == expFifo[fifoHead], "R5", "read data", rdata, expFifo[fifoHead]);
          fifoHead++;
        end else begin
          chk(1'b0, "R5", "unexpected rvalid", rdata, 32'd0);
        end
        readPending = 1'b0;
      end
      // counters advance after the checks
      rasHighCnt   = rasN ? rasHighCnt + 1 : 0;
      rasLowCnt    = rasN ? 0 : rasLowCnt + 1;
      casLowCnt    = casN ? 0 : casLowCnt + 1;
      sinceCasRise = (casN && !prevCasN) ? 0 : sinceCasRise + 1;
      sinceRasFall = (!rasN && prevRasN) ? 0 : sinceRasFall + 1;
      readLat      = (!casN && prevCasN && weN) ? 0 : readLat + 1;
    end
    prevRasN = rasN;
    prevCasN = casN;
    prevWeN  = weN;
    prevDqOe = dqOe;
  end

  task automatic issue(input bit w, input logic [3:0] r, input logic [3:0] c,
                       input logic [31:0] d);
    req     = 1'b1;
    weIn    = w;
    rowIn   = ROW_W'(r);
    colIn   = COL_W'(c);
    wdataIn = d;
    @(negedge clk);
    while (!ready) @(negedge clk);
    if (w) expMem[{r, c}] = d;
    else begin
      expFifo[fifoTail] = expMem[{r, c}];
      fifoTail++;
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1-watchdog: run hung, actual timeout expected completion");
    finishSim();
  end

  initial begin
    int expAct;
    int actBefore;
    logic [3:0] lastRow;
    for (int i = 0; i < 256; i++) begin
      modelMem[i] = 32'h1000_0000 + i * 32'h0001_0203;
      expMem[i]   = 32'h1000_0000 + i * 32'h0001_0203;
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk({rasN, casN, weN, dqOe, ready, rvalid} == 6'b111000, "R1", "reset outputs",
        {26'b0, rasN, casN, weN, dqOe, ready, rvalid}, 32'h38);
    @(posedge clk);
    #1 rstN = 1'b1;
    monOn = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // table walk: R2, R3, R5, R6, R7 via the monitor
    expAct = 0;
    lastRow = 4'hF;
    for (int i = 0; i < NVEC; i++) begin
      if (i == 0 || VEC[i][39:36] != lastRow) expAct++;
      lastRow = VEC[i][39:36];
      issue(VEC[i][40], VEC[i][39:36], VEC[i][35:32], VEC[i][31:0]);
    end
    req = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    // R10: row closed after the stream ends
    chk(rasN && casN, "R10", "row closed after idle", {30'b0, rasN, casN}, 32'd3);
    // R2 / R3: one activation per row change
    chk(activations == expAct, "R2", "activation count", activations, expAct);
    chk(fifoHead == fifoTail, "R5", "all reads returned", fifoHead, fifoTail);

    // R8: long same-row stream is split by the page time limit
    actBefore = activations;
    for (int i = 0; i < 30; i++) issue(1'b0, 4'd5, 4'(i % 16), 32'h0);
    req = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(activations - actBefore >= 2, "R8", "page reopened after limit",
        activations - actBefore, 32'd2);
    chk(fifoHead == fifoTail, "R8", "reads across page split", fifoHead, fifoTail);

    // R7 directed: read then write then read back in one row
    issue(1'b0, 4'd7, 4'd4, 32'h0);
    issue(1'b1, 4'd7, 4'd4, 32'hA5A55A5A);
    issue(1'b0, 4'd7, 4'd4, 32'h0);
    req = 1'b0;
    repeat (15) @(posedge clk);
    @(negedge clk);
    chk(fifoHead == fifoTail, "R7", "turnaround reads returned", fifoHead, fifoTail);
    chk(rdata == 32'hA5A55A5A, "R6", "written word read back", rdata, 32'hA5A55A5A);
    chk(rasN, "R10", "idle after directed case", {31'b0, rasN}, 32'd1);

    finishSim();
  end

endmodule